// File: doc/BRIEF.md
# Word-to-Byte Parity Buffer Between DMA and SCSI Paths

This block sits between a DMA port and an 8-bit SCSI data path and holds up to sixteen bytes, each stored with its own parity bit. The DMA port is either one byte lane or two byte lanes wide. In the wide case the block splits each incoming word into two stored bytes and joins two stored bytes into each outgoing word, always with the low lane first. A direction input selects the flow. With DMA-to-SCSI flow, the DMA side fills the buffer and the SCSI side drains it. With SCSI-to-DMA flow, the roles are reversed.

A burst request to the DMA controller is raised when the DMA side can move a whole burst. That means enough free slots when DMA is filling the buffer, or enough stored bytes when DMA is draining it. DMA-side parity has two modes. In the first, the block computes odd parity itself for every byte that arrives and verifies it on every byte that leaves. In the second, it stores the parity bits it receives and hands them on untouched. Sticky flags record rejected writes, rejected reads and parity mismatches until software clears them. A flush input discards all contents at once.

Top module: `dma_scsi_buf`

## Requirements
- R1: The buffer holds at most DEPTH (16) bytes. `count` reports occupancy from 0 to 16 and is 0 after reset.
- R2: With `bus_mode` not 0 (two-lane mode), a DMA write stores `dma_wdata[7:0]` before `dma_wdata[15:8]`. A DMA read presents the oldest byte on `dma_rdata[7:0]` and the next oldest on `dma_rdata[15:8]`, with `dma_rpar[0]` and `dma_rpar[1]` as their parity bits.
- R3: With `bus_mode` equal to 0 (one-lane mode), each DMA transfer moves one byte on lane 0 only, and `dma_rdata[15:8]` and `dma_rpar[1]` read as 0.
- R4: In two-lane mode, a DMA write is accepted only if at least 2 slots are free, and a DMA read only if at least 2 bytes are stored. Otherwise the transfer is ignored, `count` is unchanged, and `ovf` or `udf` respectively is set.
- R5: A write that finds too little room, or a read that finds too few bytes, leaves the contents unchanged and sets `ovf` or `udf`. Both flags stay set until `err_clr` is pulsed, and they read 0 after reset.
- R6: With `par_gen`=1, the parity stored for a DMA-written byte is odd parity: the byte together with its parity bit has an odd number of ones. `dma_wpar` is ignored.
- R7: With `par_gen`=0, the parity bits given with DMA-written bytes are stored and forwarded unchanged, and a DMA read never sets `par_err`.
- R8: With `par_gen`=1, every byte leaving through an accepted DMA read is tested against odd parity. A mismatch sets `par_err`, which stays set until `err_clr` is pulsed.
- R9: `dreq` is 1 exactly when at least BURST (8) slots are free while `to_scsi`=1, or when at least BURST bytes are stored while `to_scsi`=0.
- R10: `flush` empties the buffer in one cycle. Transfers requested in the same cycle are dropped and leave the flags unchanged.
- R11: With `to_scsi`=1, only `dma_wr` and `scsi_rd` act. With `to_scsi`=0, only `scsi_wr` and `dma_rd` act. The other strobes have no effect.
- R12: Bytes written from the SCSI side are stored with `scsi_wpar` unchanged. `scsi_rdata` and `scsi_rpar` show the oldest stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 2 | 0 selects one-lane DMA; any other value selects two lanes |
| par_gen | input | 1 | 1 = generate and check DMA parity, 0 = pass parity through |
| to_scsi | input | 1 | 1 = DMA fills and SCSI drains; 0 = SCSI fills and DMA drains |
| flush | input | 1 | Empty the buffer |
| err_clr | input | 1 | Clear ovf, udf and par_err |
| dma_wr | input | 1 | DMA write strobe |
| dma_wdata | input | 16 | DMA write data, two byte lanes |
| dma_wpar | input | 2 | DMA write parity, one bit per lane |
| dma_rd | input | 1 | DMA read strobe |
| dma_rdata | output | 16 | DMA read data |
| dma_rpar | output | 2 | DMA read parity |
| scsi_wr | input | 1 | SCSI-side write strobe |
| scsi_wdata | input | 8 | SCSI-side write byte |
| scsi_wpar | input | 1 | SCSI-side write parity |
| scsi_rd | input | 1 | SCSI-side read strobe |
| scsi_rdata | output | 8 | Oldest stored byte |
| scsi_rpar | output | 1 | Parity of oldest stored byte |
| count | output | 5 | Stored byte count |
| dreq | output | 1 | Burst request to DMA |
| ovf | output | 1 | Sticky rejected-write flag |
| udf | output | 1 | Sticky rejected-read flag |
| par_err | output | 1 | Sticky DMA parity mismatch flag |

## Verification
The hardest case to reach is the partial-room edge of two-lane mode. A word write has to arrive when exactly one slot is free, and a word read when exactly one byte is stored. Only then does the block refuse a transfer that a one-lane transfer would still satisfy. The stimulus fills the buffer to 16 with word writes and drains one byte from the SCSI side, which leaves 15 stored, before issuing the word write. For the read case it leaves a single stored byte, issues a word read, and then switches to one-lane mode to show that the same byte is still readable. A parity-check failure is provoked by feeding a byte with deliberately wrong parity in from the SCSI side and reading it out on the DMA side.

// File: rtl/dsbuf_pkg.sv
package dsbuf_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       par;
    } slot_t;

    typedef struct packed {
        logic ovf;
        logic udf;
        logic perr;
    } flags_t;

    function automatic logic odd_bit(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/byte_ring.sv
module byte_ring
    import dsbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  slot_t         push0,
    input  slot_t         push1,
    input  logic [1:0]    pop_n,
    output slot_t         head0,
    output slot_t         head1,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    slot_t mem_d [DEPTH];
    slot_t mem_q [DEPTH];
    logic [AW-1:0] wp_next1;
    logic [AW-1:0] rp_next1;

    assign wp_next1 = ring_q.wp + AW'(1);
    assign rp_next1 = ring_q.rp + AW'(1);

    always_comb begin
        ring_d = ring_q;
        mem_d  = mem_q;
        if (flush) begin
            ring_d.rp  = ring_q.wp;
            ring_d.cnt = '0;
        end else begin
            if (push_n != 2'd0) begin
                mem_d[ring_q.wp] = push0;
            end
            if (push_n == 2'd2) begin
                mem_d[wp_next1] = push1;
            end
            ring_d.wp  = ring_q.wp + AW'(push_n);
            ring_d.rp  = ring_q.rp + AW'(pop_n);
            ring_d.cnt = ring_q.cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            ring_q <= ring_d;
            mem_q  <= mem_d;
        end
    end

    assign head0 = mem_q[ring_q.rp];
    assign head1 = mem_q[rp_next1];
    assign count = ring_q.cnt;

endmodule

// File: rtl/lane_parity.sv
module lane_parity
    import dsbuf_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] wbytes,
    input  logic [LANES*8-1:0] rbytes,
    input  logic [LANES-1:0]   rpar,
    output logic [LANES-1:0]   gen_par,
    output logic [LANES-1:0]   mism
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign gen_par[g] = odd_bit(wbytes[g*8 +: 8]);
        assign mism[g]    = odd_bit(rbytes[g*8 +: 8]) != rpar[g];
    end

endmodule

// File: rtl/burst_req.sv
module burst_req #(
    parameter int DEPTH = 16,
    parameter int BURST = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic          to_scsi,
    output logic          dreq
);

    logic [CW-1:0] free;

    assign free = CW'(DEPTH) - count;
    assign dreq = to_scsi ? (free >= CW'(BURST)) : (count >= CW'(BURST));

endmodule

// File: rtl/dma_scsi_buf.sv
module dma_scsi_buf
    import dsbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   bus_mode,
    input  logic                         par_gen,
    input  logic                         to_scsi,
    input  logic                         flush,
    input  logic                         err_clr,
    input  logic                         dma_wr,
    input  logic [15:0]                  dma_wdata,
    input  logic [1:0]                   dma_wpar,
    input  logic                         dma_rd,
    output logic [15:0]                  dma_rdata,
    output logic [1:0]                   dma_rpar,
    input  logic                         scsi_wr,
    input  logic [7:0]                   scsi_wdata,
    input  logic                         scsi_wpar,
    input  logic                         scsi_rd,
    output logic [7:0]                   scsi_rdata,
    output logic                         scsi_rpar,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         dreq,
    output logic                         ovf,
    output logic                         udf,
    output logic                         par_err
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          wide;
    logic [1:0]    dma_n, wr_need, rd_need, push_n, pop_n;
    logic          wr_req, rd_req, wr_ok, rd_ok, bad_par;
    logic [CW-1:0] cnt, free;
    slot_t         push0, push1, head0, head1;
    logic [1:0]    gen_par, mism;
    flags_t        fl_d, fl_q;

    assign wide    = (bus_mode != 2'b00);
    assign dma_n   = wide ? 2'd2 : 2'd1;
    assign free    = CW'(DEPTH) - cnt;
    assign wr_req  = to_scsi ? dma_wr : scsi_wr;
    assign rd_req  = to_scsi ? scsi_rd : dma_rd;
    assign wr_need = to_scsi ? dma_n : 2'd1;
    assign rd_need = to_scsi ? 2'd1 : dma_n;
    assign wr_ok   = wr_req && !flush && (free >= CW'(wr_need));
    assign rd_ok   = rd_req && !flush && (cnt >= CW'(rd_need));
    assign push_n  = wr_ok ? wr_need : 2'd0;
    assign pop_n   = rd_ok ? rd_need : 2'd0;

    lane_parity #(.LANES(2)) par_i (
        .wbytes  (dma_wdata),
        .rbytes  ({head1.data, head0.data}),
        .rpar    ({head1.par, head0.par}),
        .gen_par (gen_par),
        .mism    (mism)
    );

    assign push0 = to_scsi ? {dma_wdata[7:0], (par_gen ? gen_par[0] : dma_wpar[0])}
                           : {scsi_wdata, scsi_wpar};
    assign push1 = {dma_wdata[15:8], (par_gen ? gen_par[1] : dma_wpar[1])};

    byte_ring #(.DEPTH(DEPTH)) ring_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .push_n (push_n),
        .push0  (push0),
        .push1  (push1),
        .pop_n  (pop_n),
        .head0  (head0),
        .head1  (head1),
        .count  (cnt)
    );

    burst_req #(.DEPTH(DEPTH), .BURST(BURST)) req_i (
        .count   (cnt),
        .to_scsi (to_scsi),
        .dreq    (dreq)
    );

    assign bad_par = par_gen && !to_scsi && rd_ok && (mism[0] || (wide && mism[1]));

    always_comb begin
        fl_d = fl_q;
        if (err_clr) begin
            fl_d = '0;
        end
        if (wr_req && !flush && !wr_ok) begin
            fl_d.ovf = 1'b1;
        end
        if (rd_req && !flush && !rd_ok) begin
            fl_d.udf = 1'b1;
        end
        if (bad_par) begin
            fl_d.perr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign scsi_rdata = head0.data;
    assign scsi_rpar  = head0.par;
    assign dma_rdata  = wide ? {head1.data, head0.data} : {8'h00, head0.data};
    assign dma_rpar   = wide ? {head1.par, head0.par} : {1'b0, head0.par};
    assign count      = cnt;
    assign ovf        = fl_q.ovf;
    assign udf        = fl_q.udf;
    assign par_err    = fl_q.perr;

endmodule

// File: rtl/dma_scsi_buf_chk.sv
module dma_scsi_buf_chk #(
    parameter int DEPTH = 16,
    parameter int BURST = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 bus_mode,
    input logic                       par_gen,
    input logic                       to_scsi,
    input logic                       flush,
    input logic                       err_clr,
    input logic                       dma_wr,
    input logic                       dma_rd,
    input logic                       scsi_rd,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       dreq,
    input logic                       ovf,
    input logic                       udf,
    input logic                       par_err
);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    assert_wide_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (to_scsi && dma_wr && !scsi_rd && !flush && bus_mode != 2'b00 && (DEPTH - int'(count)) < 2)
        |=> (ovf && $stable(count)));

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_scsi && dma_rd && !flush && count == '0) |=> udf);

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !err_clr) |=> ovf);

    assert_udf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (udf && !err_clr) |=> udf);

    assert_pass_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_gen && !par_err) |=> !par_err);

    assert_perr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !err_clr) |=> par_err);

    assert_dreq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dreq == (to_scsi ? ((DEPTH - int'(count)) >= BURST) : (int'(count) >= BURST)));

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

endmodule

bind dma_scsi_buf dma_scsi_buf_chk #(.DEPTH(DEPTH), .BURST(BURST)) chk_i (.*);

// File: tb/dma_scsi_buf_tb_top.sv
`timescale 1ns/1ps
module dma_scsi_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'd1;
    logic        par_gen = 1'b1;
    logic        to_scsi = 1'b0;
    logic        flush = 1'b0;
    logic        err_clr = 1'b0;
    logic        dma_wr = 1'b0;
    logic [15:0] dma_wdata = '0;
    logic [1:0]  dma_wpar = '0;
    logic        dma_rd = 1'b0;
    logic [15:0] dma_rdata;
    logic [1:0]  dma_rpar;
    logic        scsi_wr = 1'b0;
    logic [7:0]  scsi_wdata = '0;
    logic        scsi_wpar = 1'b0;
    logic        scsi_rd = 1'b0;
    logic [7:0]  scsi_rdata;
    logic        scsi_rpar;
    logic [4:0]  count;
    logic        dreq, ovf, udf, par_err;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [8:0]  exp_q[$];
    logic        exp_perr = 1'b0;
    string       mon_req = "R12";

    always #5 clk = ~clk;

    dma_scsi_buf dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .par_gen(par_gen),
        .to_scsi(to_scsi), .flush(flush), .err_clr(err_clr),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_wpar(dma_wpar),
        .dma_rd(dma_rd), .dma_rdata(dma_rdata), .dma_rpar(dma_rpar),
        .scsi_wr(scsi_wr), .scsi_wdata(scsi_wdata), .scsi_wpar(scsi_wpar),
        .scsi_rd(scsi_rd), .scsi_rdata(scsi_rdata), .scsi_rpar(scsi_rpar),
        .count(count), .dreq(dreq), .ovf(ovf), .udf(udf), .par_err(par_err)
    );

    function automatic logic oddp(input logic [7:0] b);
        return ~(^b);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // driver: DMA write, pushes expected slots when room allows
    task automatic dw(input logic [15:0] w, input logic [1:0] p);
        int n = (bus_mode != 2'd0) ? 2 : 1;
        if (16 - exp_q.size() >= n) begin
            exp_q.push_back({w[7:0], par_gen ? oddp(w[7:0]) : p[0]});
            if (n == 2) exp_q.push_back({w[15:8], par_gen ? oddp(w[15:8]) : p[1]});
        end
        dma_wr = 1'b1; dma_wdata = w; dma_wpar = p;
        tick();
        dma_wr = 1'b0;
    endtask

    task automatic sw(input logic [7:0] b, input logic p);
        if (exp_q.size() < 16) exp_q.push_back({b, p});
        scsi_wr = 1'b1; scsi_wdata = b; scsi_wpar = p;
        tick();
        scsi_wr = 1'b0;
    endtask

    task automatic srd();
        scsi_rd = 1'b1;
        tick();
        scsi_rd = 1'b0;
    endtask

    task automatic drd();
        dma_rd = 1'b1;
        tick();
        dma_rd = 1'b0;
    endtask

    task automatic clr();
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        exp_perr = 1'b0;
    endtask

    // monitor: compares read data against the scoreboard away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !flush) begin
            if (to_scsi && scsi_rd && exp_q.size() >= 1) begin
                chk({scsi_rdata, scsi_rpar} == exp_q[0], mon_req, {scsi_rdata, scsi_rpar}, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (!to_scsi && dma_rd) begin
                automatic int n = (bus_mode != 2'd0) ? 2 : 1;
                if (exp_q.size() >= n) begin
                    automatic logic [8:0] e0 = exp_q.pop_front();
                    chk({dma_rdata[7:0], dma_rpar[0]} == e0, "R2", {dma_rdata[7:0], dma_rpar[0]}, e0);
                    if (par_gen && oddp(e0[8:1]) != e0[0]) exp_perr = 1'b1;
                    if (n == 2) begin
                        automatic logic [8:0] e1 = exp_q.pop_front();
                        chk({dma_rdata[15:8], dma_rpar[1]} == e1, "R2", {dma_rdata[15:8], dma_rpar[1]}, e1);
                        if (par_gen && oddp(e1[8:1]) != e1[0]) exp_perr = 1'b1;
                    end else begin
                        chk({dma_rdata[15:8], dma_rpar[1]} == 9'h0, "R3", {dma_rdata[15:8], dma_rpar[1]}, 0);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(count == 0, "R1", count, 0);
        chk(dreq == 0, "R9", dreq, 0);
        chk({ovf, udf, par_err} == 3'b0, "R5", {ovf, udf, par_err}, 0);

        // R11: DMA write while SCSI fills is ignored
        dma_wr = 1'b1; dma_wdata = 16'hBEEF;
        tick();
        dma_wr = 1'b0;
        chk(count == 0 && ovf == 0, "R11", {ovf, count}, 0);

        // SCSI fills 8 bytes, byte 5 with wrong parity
        for (int i = 0; i < 8; i++) begin
            sw(8'h30 + 8'(i), (i == 5) ? ~oddp(8'h30 + 8'(i)) : oddp(8'h30 + 8'(i)));
            if (i == 6) chk(dreq == 0, "R9", dreq, 0);
        end
        chk(count == 8, "R1", count, 8);
        chk(dreq == 1, "R9", dreq, 1);

        // two-lane DMA reads, parity check
        for (int i = 0; i < 4; i++) begin
            drd();
            chk(par_err == exp_perr, "R8", par_err, exp_perr);
        end
        chk(count == 0, "R1", count, 0);
        chk(par_err == 1, "R8", par_err, 1);
        clr();
        chk({ovf, udf, par_err} == 3'b0, "R5", {ovf, udf, par_err}, 0);

        // underflow on empty, then partial room for a word read
        drd();
        chk(udf == 1 && count == 0, "R5", {udf, count}, 6'h20);
        clr();
        sw(8'hA5, oddp(8'hA5));
        drd();
        chk(udf == 1 && count == 1, "R4", {udf, count}, 6'h21);
        bus_mode = 2'd0;
        drd();
        chk(count == 0, "R3", count, 0);
        clr();

        // DMA to SCSI, generated parity with wrong incoming bits
        to_scsi = 1'b1; bus_mode = 2'd1;
        #1 chk(dreq == 1, "R9", dreq, 1);
        for (int i = 0; i < 8; i++) begin
            dw({8'(2*i + 1) ^ 8'h5A, 8'(2*i) ^ 8'hC3}, 2'b00);
            if (i == 3) chk(dreq == 1, "R9", dreq, 1);
            if (i == 4) chk(dreq == 0, "R9", dreq, 0);
        end
        chk(count == 16, "R1", count, 16);
        dw(16'h1234, 2'b00);
        chk(ovf == 1 && count == 16, "R5", {ovf, count}, 6'h30);
        clr();
        mon_req = "R6";
        srd();
        dw(16'h5678, 2'b00);
        chk(ovf == 1 && count == 15, "R4", {ovf, count}, 6'h2F);
        clr();
        bus_mode = 2'd0;
        dw(16'h00C3, 2'b00);
        chk(count == 16 && ovf == 0, "R3", {ovf, count}, 16);

        // R11: SCSI write while DMA fills is ignored
        scsi_wr = 1'b1; scsi_wdata = 8'h77;
        tick();
        scsi_wr = 1'b0;
        chk(count == 16 && ovf == 0, "R11", {ovf, count}, 16);
        for (int i = 0; i < 16; i++) srd();
        chk(count == 0, "R1", count, 0);

        // pass-through parity
        par_gen = 1'b0; bus_mode = 2'd1; mon_req = "R7";
        dw(16'h0F01, 2'b10);
        dw(16'h7733, 2'b01);
        for (int i = 0; i < 4; i++) srd();
        to_scsi = 1'b0;
        sw(8'h11, 1'b0);
        sw(8'h22, 1'b0);
        drd();
        chk(par_err == 0, "R7", par_err, 0);
        chk(count == 0, "R7", count, 0);

        // flush with a simultaneous write
        for (int i = 0; i < 3; i++) sw(8'h40 + 8'(i), 1'b1);
        chk(count == 3, "R12", count, 3);
        flush = 1'b1; scsi_wr = 1'b1;
        exp_q.delete();
        tick();
        flush = 1'b0; scsi_wr = 1'b0;
        chk(count == 0 && ovf == 0, "R10", {ovf, count}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule